// File: doc/BRIEF.md
# Serial Shifter with Configurable Pin Routing

This block moves one byte at a time between a parallel transmit register, a parallel receive register and three serial pins: a shift clock pin and two data pins, called O and I here. Three configuration bits decide how the internal shift path reaches the pins. They select whether the unit is clock master, whether both directions share pin O, and whether the fixed routing applies. In the fixed routing, transmit always uses O and receive always uses I. Each pin is modelled as separate input, output and output-enable signals, so an enclosing pad ring can tri-state any pin that the current configuration does not drive.

A start pulse begins one 8-bit frame, shifted most significant bit first. Data changes on the falling edge of the shift clock and is captured on the rising edge. The clock idles high. As master, the unit divides the system clock by twice a programmable half-period and drives the clock pin. As slave, it takes the clock pin through a synchronizer and acts on the detected edges. At the end of the frame, a one-cycle done pulse is raised and the received byte becomes visible.

Top module: `ser_shift_unit`

## Requirements
- R1: With cfg_fixed=0, cfg_bidir=0 and cfg_master=1, the transmitted bits appear on pin_o_out with pin_o_oe high, pin_i_oe stays low, and received bits are taken from pin_i_in.
- R2: With cfg_fixed=0, cfg_bidir=0 and cfg_master=0, the roles swap: transmitted bits appear on pin_i_out with pin_i_oe high, pin_o_oe stays low, and received bits are taken from pin_o_in.
- R3: With cfg_fixed=0 and cfg_bidir=1, pin_i_oe is never high. If tx_en and rx_en are both 1, the unit only transmits on pin O, dir_conflict is 1, and rx_data does not change at the end of the frame. This holds in master and in slave.
- R4: With cfg_fixed=0, cfg_bidir=1, tx_en=0 and rx_en=1, both output enables stay low and the received byte is taken from pin_o_in.
- R5: With cfg_fixed=1, transmit uses pin O and receive uses pin I in master and in slave, regardless of cfg_bidir, and dir_conflict stays 0.
- R6: sck_oe equals cfg_master, and sck_out is high whenever the unit is master and no frame is running.
- R7: As master, each frame produces exactly 8 falling edges on sck_out. Consecutive falling edges are 2*div_half system clock cycles apart, and sck_out ends high.
- R8: Bits leave most significant first and change only on falling shift-clock edges. Received bits are captured on rising edges, so the peer sees tx_data and rx_data holds the byte the peer presented.
- R9: done is high for exactly one cycle per frame, after the eighth rising edge. rx_data changes only in a cycle where done is high, and busy is low from that cycle on.
- R10: A start pulse is ignored while busy is high, or when tx_en and rx_en are both 0. busy only rises in the cycle after an accepted start.
- R11: After reset, busy=0, done=0, rx_data=0 and sck_out=1.
- R12: As slave, edges on sck_in while no frame is running shift nothing: busy stays 0, no done pulse appears, and rx_data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1: unit generates the shift clock; 0: clock comes from sck_in |
| cfg_bidir | input | 1 | 1: both directions share pin O (when cfg_fixed=0) |
| cfg_fixed | input | 1 | 1: transmit on O, receive on I in every role |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| div_half | input | DIV_W | Master half-period in system cycles (0 acts as 1) |
| tx_data | input | DATA_W | Byte loaded into the shift path at start |
| start | input | 1 | One-cycle request to shift one frame |
| sck_in | input | 1 | Clock pin input (slave) |
| sck_out | output | 1 | Clock pin output value (master) |
| sck_oe | output | 1 | Clock pin output enable |
| pin_o_in | input | 1 | Data pin O input |
| pin_o_out | output | 1 | Data pin O output value |
| pin_o_oe | output | 1 | Data pin O output enable |
| pin_i_in | input | 1 | Data pin I input |
| pin_i_out | output | 1 | Data pin I output value |
| pin_i_oe | output | 1 | Data pin I output enable |
| rx_data | output | DATA_W | Last received byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| dir_conflict | output | 1 | Shared-pin mode with both directions enabled |

## Verification
The bench drives the correct byte on the expected receive pin and its complement on the other data pin. A routing mix-up therefore shows up as an inverted receive byte or a wrong transmit capture, not as a silent pass. The shared-pin cases with both enables set catch a design that lets receive win, drives pin I, or overwrites rx_data. Those cases also check that the fixed-routing bit overrides the shared-pin bit. The timing cases check the exact spacing of falling edges and that the first bit is present before the first falling edge without being shifted away. A second start in mid-frame, a start with no direction enabled and stray slave clock edges while idle each show whether the design starts a frame it should have ignored.

// File: rtl/ssu_pkg.sv
// Shared types for the serial shifter.
// Assumes: consumers import the package; no state lives here.
package ssu_pkg;

    // How the data pins relate to the shift path.
    typedef enum logic [1:0] {
        LINK_STD   = 2'd0,  // separate pins, roles follow master/slave
        LINK_SHARE = 2'd1,  // both directions on pin O
        LINK_FIXED = 2'd2   // transmit O, receive I in every role
    } link_mode_e;

    // Decoded routing for one configuration.
    typedef struct packed {
        logic tx_act;     // transmit path active
        logic rx_act;     // receive path active (result may be stored)
        logic tx_on_i;    // transmit driven on pin I instead of O
        logic rx_from_o;  // receive taken from pin O instead of I
        logic conflict;   // shared pin asked for both directions
    } route_t;

endpackage

// File: rtl/ssu_route.sv
// Routing decoder: turns the configuration bits into the pin roles
// and the active directions.
// Assumes: configuration is held stable while a frame runs.
module ssu_route
    import ssu_pkg::*;
(
    input  logic   master,
    input  logic   bidir,
    input  logic   fixed,
    input  logic   tx_en,
    input  logic   rx_en,
    output route_t rt
);

    link_mode_e mode;

    // Pick the link mode; fixed routing overrides the shared-pin bit.
    always_comb begin
        if (fixed)      mode = LINK_FIXED;
        else if (bidir) mode = LINK_SHARE;
        else            mode = LINK_STD;
    end

    // Decode pin roles and active directions for the selected mode.
    always_comb begin
        rt.tx_act    = tx_en;
        rt.rx_act    = rx_en;
        rt.tx_on_i   = 1'b0;
        rt.rx_from_o = 1'b0;
        rt.conflict  = 1'b0;
        case (mode)
            LINK_STD: begin
                rt.tx_on_i   = ~master;
                rt.rx_from_o = ~master;
            end
            LINK_SHARE: begin
                rt.rx_from_o = 1'b1;
                rt.rx_act    = rx_en & ~tx_en;
                rt.conflict  = rx_en & tx_en;
            end
            default: begin
                rt.tx_on_i   = 1'b0;
                rt.rx_from_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ssu_pinmux.sv
// Pin multiplexer: steers the serial output bit to the selected data
// pin with its output enable, and selects the receive input pin.
// Assumes: route information comes from ssu_route.
module ssu_pinmux
    import ssu_pkg::*;
(
    input  route_t rt,
    input  logic   tx_bit,
    input  logic   pin_o_in,
    input  logic   pin_i_in,
    output logic   pin_o_out,
    output logic   pin_o_oe,
    output logic   pin_i_out,
    output logic   pin_i_oe,
    output logic   rx_bit
);

    // Drive only the transmit pin; an unused pin is tri-stated and held low.
    always_comb begin
        pin_o_oe  = rt.tx_act & ~rt.tx_on_i;
        pin_i_oe  = rt.tx_act &  rt.tx_on_i;
        pin_o_out = pin_o_oe & tx_bit;
        pin_i_out = pin_i_oe & tx_bit;
    end

    // Select the pin whose level feeds the receive shift path.
    always_comb begin
        rx_bit = rt.rx_from_o ? pin_o_in : pin_i_in;
    end

endmodule

// File: rtl/ssu_clkgen.sv
// Shift clock source: as master divides the system clock by 2*half_div
// and reports each generated edge; as slave synchronizes the clock pin
// and reports its edges. The clock idles high in both roles.
// Assumes: external clock half-periods exceed SYNC_STAGES+1 system cycles.
module ssu_clkgen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    input  logic             sck_in,
    output logic             sck_drv,
    output logic             fall_evt,
    output logic             rise_evt
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0]       half_eff;
    logic [DIV_W-1:0]       cnt_q;
    logic                   tick_m;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sck_sync;
    logic                   prev_q;
    logic                   s_fall;
    logic                   s_rise;

    // Half-period of zero is treated as one cycle.
    assign half_eff = (half_div == '0) ? ONE : half_div;
    assign tick_m   = run & master & (cnt_q == half_eff - ONE);

    // Master divider: count a half-period, then toggle the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sck_drv <= 1'b1;
        end else if (run && master) begin
            if (tick_m) begin
                cnt_q   <= '0;
                sck_drv <= ~sck_drv;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end else begin
            cnt_q   <= '0;
            sck_drv <= 1'b1;
        end
    end

    // Synchronizer for the external clock; depth picks the structure.
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= sck_in;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
            end
        end
    endgenerate

    assign sck_sync = sync_q[SYNC_STAGES-1];

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sck_sync;
    end

    assign s_fall = prev_q & ~sck_sync;
    assign s_rise = ~prev_q & sck_sync;

    // Report edges from the active clock source while a frame runs.
    always_comb begin
        if (master) begin
            fall_evt = tick_m & sck_drv;
            rise_evt = tick_m & ~sck_drv;
        end else begin
            fall_evt = run & s_fall;
            rise_evt = run & s_rise;
        end
    end

endmodule

// File: rtl/ssu_shifter.sv
// Frame engine: loads the transmit byte at start, presents the MSB,
// shifts the transmit path on falling edges after the first, captures
// the receive path on rising edges, and closes the frame after
// DATA_W rising edges with a one-cycle done pulse.
// Assumes: edge strobes are single-cycle and never coincide.
module ssu_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tx_act,
    input  logic              rx_act,
    input  logic              fall_evt,
    input  logic              rise_evt,
    input  logic              rx_bit,
    input  logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic              done,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_data
);

    localparam int                CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CONE  = CNT_W'(1);

    logic              first_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] rx_next;
    logic              accept;
    logic              last_rise;

    assign accept    = start & ~busy & (tx_act | rx_act);
    assign rx_next   = {rx_sr[DATA_W-2:0], rx_bit};
    assign last_rise = busy & rise_evt & (cnt_q == LAST);
    assign tx_bit    = tx_sr[DATA_W-1];

    // Frame control: busy, first-edge marker, bit count and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            first_q <= 1'b0;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                first_q <= 1'b1;
                cnt_q   <= '0;
            end else if (busy) begin
                if (fall_evt) first_q <= 1'b0;
                if (rise_evt) begin
                    cnt_q <= cnt_q + CONE;
                    if (cnt_q == LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    // Transmit path: load at start, shift on every falling edge but the first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (accept) begin
            tx_sr <= tx_data;
        end else if (busy && fall_evt && !first_q) begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    // Receive path: capture on rising edges, publish at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr   <= '0;
            rx_data <= '0;
        end else begin
            if (busy && rise_evt) rx_sr <= rx_next;
            if (last_rise && rx_act) rx_data <= rx_next;
        end
    end

endmodule

// File: rtl/ser_shift_unit.sv
// Serial shifter top: ties routing decode, pin multiplexer, shift clock
// source and frame engine together. Pins are split into input, output
// and output-enable signals for an external pad ring.
// Assumes: configuration and enables are stable during a frame.
module ser_shift_unit
    import ssu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_bidir,
    input  logic              cfg_fixed,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [DIV_W-1:0]  div_half,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              start,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              pin_o_in,
    output logic              pin_o_out,
    output logic              pin_o_oe,
    input  logic              pin_i_in,
    output logic              pin_i_out,
    output logic              pin_i_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    output logic              dir_conflict
);

    route_t rt;
    logic   tx_bit;
    logic   rx_bit;
    logic   fall_evt;
    logic   rise_evt;

    ssu_route u_route (
        .master (cfg_master),
        .bidir  (cfg_bidir),
        .fixed  (cfg_fixed),
        .tx_en  (tx_en),
        .rx_en  (rx_en),
        .rt     (rt)
    );

    ssu_pinmux u_pinmux (
        .rt        (rt),
        .tx_bit    (tx_bit),
        .pin_o_in  (pin_o_in),
        .pin_i_in  (pin_i_in),
        .pin_o_out (pin_o_out),
        .pin_o_oe  (pin_o_oe),
        .pin_i_out (pin_i_out),
        .pin_i_oe  (pin_i_oe),
        .rx_bit    (rx_bit)
    );

    ssu_clkgen #(
        .DIV_W       (DIV_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (cfg_master),
        .run      (busy),
        .half_div (div_half),
        .sck_in   (sck_in),
        .sck_drv  (sck_out),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt)
    );

    ssu_shifter #(
        .DATA_W (DATA_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tx_act   (rt.tx_act),
        .rx_act   (rt.rx_act),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .rx_bit   (rx_bit),
        .tx_data  (tx_data),
        .busy     (busy),
        .done     (done),
        .tx_bit   (tx_bit),
        .rx_data  (rx_data)
    );

    // The clock pin drives only in master role.
    assign sck_oe       = cfg_master;
    assign dir_conflict = rt.conflict;

endmodule

// File: rtl/ser_shift_chk.sv
// Property checker for ser_shift_unit, attached by bind.
// Assumes: observes top-level ports only.
module ser_shift_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_master,
    input logic              cfg_bidir,
    input logic              cfg_fixed,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              sck_out,
    input logic              pin_o_oe,
    input logic              pin_i_oe,
    input logic              dir_conflict,
    input logic [DATA_W-1:0] rx_data
);

    AST_SINGLE_DATA_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pin_o_oe, pin_i_oe}) <= 1); // R1

    AST_SHARED_PIN_I_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bidir && !cfg_fixed) |-> !pin_i_oe); // R3

    AST_CONFLICT_TX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dir_conflict |-> (pin_o_oe && !pin_i_oe)); // R3

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !busy) |-> sck_out); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_RX_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> done); // R9

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R10

endmodule

bind ser_shift_unit ser_shift_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_master   (cfg_master),
    .cfg_bidir    (cfg_bidir),
    .cfg_fixed    (cfg_fixed),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .sck_out      (sck_out),
    .pin_o_oe     (pin_o_oe),
    .pin_i_oe     (pin_i_oe),
    .dir_conflict (dir_conflict),
    .rx_data      (rx_data)
);

// File: tb/sim_ser_shift_unit.sv
module sim_ser_shift_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_master, cfg_bidir, cfg_fixed, tx_en, rx_en;
    logic [7:0] div_half, tx_data, rx_data;
    logic       start, sck_in, sck_out, sck_oe;
    logic       pin_o_in, pin_o_out, pin_o_oe;
    logic       pin_i_in, pin_i_out, pin_i_oe;
    logic       busy, done, dir_conflict;

    always #5 clk = ~clk;

    ser_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_bidir(cfg_bidir),
        .cfg_fixed(cfg_fixed), .tx_en(tx_en), .rx_en(rx_en), .div_half(div_half),
        .tx_data(tx_data), .start(start), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .pin_o_in(pin_o_in), .pin_o_out(pin_o_out), .pin_o_oe(pin_o_oe),
        .pin_i_in(pin_i_in), .pin_i_out(pin_i_out), .pin_i_oe(pin_i_oe),
        .rx_data(rx_data), .busy(busy), .done(done), .dir_conflict(dir_conflict)
    );

    // pin codes: 0 none, 1 pin O, 2 pin I
    typedef struct packed {
        logic       m, b, f, te, re;
        logic [7:0] dv, txb, rxb;
        logic [1:0] txpin, rxpin;
        logic       upd, conf;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,1'b1, 8'd2, 8'hA5, 8'h3C, 2'd1, 2'd2, 1'b1, 1'b0},
        '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd1, 8'h81, 8'h66, 2'd1, 2'd0, 1'b0, 1'b0},
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 8'd2, 8'h5A, 8'hC3, 2'd2, 2'd1, 1'b1, 1'b0},
        '{1'b1,1'b1,1'b0,1'b1,1'b1, 8'd3, 8'hF0, 8'h0F, 2'd1, 2'd0, 1'b0, 1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b1, 8'd2, 8'h00, 8'h96, 2'd0, 2'd1, 1'b1, 1'b0},
        '{1'b1,1'b1,1'b0,1'b0,1'b1, 8'd2, 8'h00, 8'h4B, 2'd0, 2'd1, 1'b1, 1'b0},
        '{1'b0,1'b1,1'b1,1'b1,1'b1, 8'd2, 8'h37, 8'hE1, 2'd1, 2'd2, 1'b1, 1'b0},
        '{1'b1,1'b0,1'b1,1'b1,1'b1, 8'd4, 8'hC9, 8'h2D, 2'd1, 2'd2, 1'b1, 1'b0},
        '{1'b0,1'b1,1'b0,1'b1,1'b1, 8'd2, 8'h6E, 8'h18, 2'd1, 2'd0, 1'b0, 1'b1}
    };

    int  n_chk = 0, n_bad = 0, cyc = 0, dcnt = 0;
    bit  finished = 0;

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (done) dcnt++;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_rx(input vec_t v, input int k);
        if (v.rxpin == 2'd2) begin
            pin_i_in = v.rxb[7-k];
            pin_o_in = ~v.rxb[7-k];
        end else begin
            pin_o_in = v.rxb[7-k];
            pin_i_in = ~v.rxb[7-k];
        end
    endtask

    function automatic string req_of(input vec_t v);
        if (v.f)      return "R5";
        else if (v.b) return v.te ? "R3" : "R4";
        else if (v.m) return "R1";
        else          return "R2";
    endfunction

    task automatic run_frame(input vec_t v, input bit restart);
        string      rq = req_of(v);
        logic [7:0] cap = '0;
        logic [7:0] prev;
        logic       smp;
        int         falls = 0, rises = 0, f1 = 0, f2 = 0, guard = 0;
        logic       psck;
        cfg_master = v.m; cfg_bidir = v.b; cfg_fixed = v.f;
        tx_en = v.te; rx_en = v.re; div_half = v.dv; tx_data = v.txb;
        sck_in = 1'b1; pin_o_in = 1'b0; pin_i_in = 1'b0;
        tick();
        chk(rq, "pin_o_oe", int'(pin_o_oe), int'(v.txpin == 2'd1));
        chk(rq, "pin_i_oe", int'(pin_i_oe), int'(v.txpin == 2'd2));
        chk(rq, "dir_conflict", int'(dir_conflict), int'(v.conf));
        chk("R6", "sck_oe", int'(sck_oe), int'(v.m));
        prev = rx_data;
        dcnt = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R10", "busy after start", int'(busy), 1);
        if (v.m) begin
            psck = sck_out;
            while (rises < 8 && guard < 4000) begin
                tick();
                start = 1'b0;
                guard++;
                if (sck_out != psck) begin
                    if (!sck_out) begin
                        if (falls == 0) f1 = cyc;
                        if (falls == 1) f2 = cyc;
                        drive_rx(v, falls);
                        falls++;
                        if (restart && falls == 3) begin
                            tx_data = ~v.txb;
                            start = 1'b1;
                        end
                    end else begin
                        smp = (v.txpin == 2'd2) ? pin_i_out : pin_o_out;
                        cap = {cap[6:0], smp};
                        rises++;
                    end
                    psck = sck_out;
                end
            end
            chk("R7", "falling edge spacing", f2 - f1, 2 * int'(v.dv));
            chk("R7", "falling edges", falls, 8);
        end else begin
            for (int k = 0; k < 8; k++) begin
                sck_in = 1'b0;
                drive_rx(v, k);
                repeat (6) tick();
                smp = (v.txpin == 2'd2) ? pin_i_out : pin_o_out;
                cap = {cap[6:0], smp};
                sck_in = 1'b1;
                repeat (6) tick();
            end
        end
        repeat (3) tick();
        if (v.txpin != 2'd0) chk("R8", {rq, " tx byte"}, int'(cap), int'(v.txb));
        if (restart) chk("R10", "tx byte kept after second start", int'(cap), int'(v.txb));
        chk(v.upd ? "R8" : rq, {rq, " rx_data"}, int'(rx_data), int'(v.upd ? v.rxb : prev));
        chk("R9", "done pulses", dcnt, 1);
        chk("R9", "busy cleared", int'(busy), 0);
        if (v.m) chk("R7", "sck_out ends high", int'(sck_out), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        rst_n = 1'b0; start = 1'b0; sck_in = 1'b1;
        cfg_master = 1'b1; cfg_bidir = 1'b0; cfg_fixed = 1'b0;
        tx_en = 1'b0; rx_en = 1'b0; div_half = 8'd2; tx_data = 8'h00;
        pin_o_in = 1'b0; pin_i_in = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11 reset state
        chk("R11", "busy", int'(busy), 0);
        chk("R11", "done", int'(done), 0);
        chk("R11", "rx_data", int'(rx_data), 0);
        chk("R11", "sck_out", int'(sck_out), 1);

        for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0);

        // R10: second start during a master frame
        run_frame('{1'b1,1'b0,1'b0,1'b1,1'b1, 8'd2, 8'hB4, 8'h71, 2'd1, 2'd2, 1'b1, 1'b0}, 1'b1);

        // R10: start with no direction enabled
        tx_en = 1'b0; rx_en = 1'b0; dcnt = 0;
        start = 1'b1; tick(); start = 1'b0;
        repeat (3) tick();
        chk("R10", "busy with no enable", int'(busy), 0);
        chk("R10", "done with no enable", dcnt, 0);

        // R12: slave clock edges while idle
        cfg_master = 1'b0; cfg_bidir = 1'b0; cfg_fixed = 1'b1;
        tx_en = 1'b0; rx_en = 1'b1; dcnt = 0;
        hold = rx_data;
        for (int k = 0; k < 8; k++) begin
            sck_in = 1'b0; pin_i_in = k[0]; pin_o_in = ~k[0];
            repeat (5) tick();
            sck_in = 1'b1;
            repeat (5) tick();
        end
        repeat (3) tick();
        chk("R12", "busy after idle edges", int'(busy), 0);
        chk("R12", "done after idle edges", dcnt, 0);
        chk("R12", "rx_data after idle edges", int'(rx_data), int'(hold));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule